// File: doc/BRIEF.md
# Error Source ID Capture Register

This block records who caused the first error of each class seen by a link's root error status logic. Two error reporters feed it. The internal detector reports errors found locally, and the link path reports errors carried by messages that arrive from the far end. Each reporter gives a valid strobe and a two-bit class. The link path also gives the 16-bit requester ID taken from the message. Errors from the internal detector are charged to a fixed local requester ID, which is set by a parameter.

The block keeps two fields, one for correctable errors and one for uncorrectable errors. Each field has its own first-error flag. A field loads only while its flag is clear, and loading it sets the flag. Software re-arms a field by pulsing that field's clear input. The captured values survive system reset, and only the power-on reset returns them to zero. No reporting-enable or control setting gates the capture.

Top module: `err_src_id_cap`

## Requirements
- R1: `src_id_o[31:16]` holds the uncorrectable source ID and `src_id_o[15:0]` holds the correctable source ID. Power-on reset (`rst_ni` low) sets both fields and both flags to zero.
- R2: The class code is 2'b00 for correctable, 2'b01 for uncorrectable nonfatal, 2'b10 for uncorrectable fatal and 2'b11 for reserved. Codes 01 and 10 both load the upper field. A report with code 11 is ignored.
- R3: While a class's flag is set, further errors of that class leave its field unchanged.
- R4: If internal and link errors of the same class arrive in the same clock while the flag is clear, the field stores the link requester ID.
- R5: An internal error that is captured on its own stores the parameter `LOCAL_ID`, which defaults to 16'h0010.
- R6: A capture sets that class's flag. The correctable flag is `ce_first_o` and the uncorrectable flag is `ue_first_o`.
- R7: A 1 on `clr_ce_i` or `clr_ue_i` clears only that class's flag, and the next error of that class is then captured. If a clear arrives in the same clock as an error while the flag is set, the flag clears and the field is unchanged.
- R8: The two classes are independent. If errors of both classes arrive in one clock, both fields capture in that clock.
- R9: While `sys_rst_ni` is low, fields and flags keep their values, and error strobes and clears are ignored. When system reset is released, the values are still intact.
- R10: A capture or clear shows at the outputs just after the next rising clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_ni | input | 1 | System reset, active low; sticky state is kept |
| int_vld_i | input | 1 | Internal error strobe |
| int_cls_i | input | 2 | Internal error class |
| lnk_vld_i | input | 1 | Link message error strobe |
| lnk_cls_i | input | 2 | Link message error class |
| lnk_rid_i | input | 16 | Link message requester ID |
| clr_ce_i | input | 1 | Clear the correctable first-error flag |
| clr_ue_i | input | 1 | Clear the uncorrectable first-error flag |
| src_id_o | output | 32 | {uncorrectable ID, correctable ID} |
| ce_first_o | output | 1 | Correctable first-error flag |
| ue_first_o | output | 1 | Uncorrectable first-error flag |

## Verification
The hardest states to reach are the ones where several things collide in a single clock. Examples are both reporters in one class, both classes at once, and a clear together with an error while the flag is set. The vector table drives each of these collisions from a known captured state. The table also re-arms the flags between collisions, so every collision starts from a fresh field. A directed sequence then holds system reset with live strobes and clears, releases it, and confirms that only power-on reset zeroes the register.

// File: rtl/esid_pkg.sv
package esid_pkg;
  typedef enum logic [1:0] {
    CLS_COR = 2'b00,
    CLS_UNF = 2'b01,
    CLS_FAT = 2'b10,
    CLS_RSV = 2'b11
  } err_cls_e;

  localparam int NUM_SRC = 2;   // 0: internal, 1: link
  localparam int SRC_INT = 0;
  localparam int SRC_LNK = 1;
  localparam int NUM_CLS = 2;   // 0: correctable, 1: uncorrectable

  typedef struct packed {
    logic unc;
    logic cor;
  } cls_hit_t;
endpackage

// File: rtl/esid_classify.sv
module esid_classify
  import esid_pkg::*;
(
  input  logic     vld_i,
  input  err_cls_e cls_i,
  input  logic     en_i,
  output cls_hit_t hit_o
);
  always_comb begin
    hit_o = '0;
    if (vld_i && en_i) begin
      unique case (cls_i)
        CLS_COR:          hit_o.cor = 1'b1;
        CLS_UNF, CLS_FAT: hit_o.unc = 1'b1;
        default:          hit_o = '0;  // reserved code ignored
      endcase
    end
  end
endmodule

// File: rtl/esid_field.sv
module esid_field #(
  parameter int                ID_W     = 16,
  parameter logic [ID_W-1:0]   LOCAL_ID = 16'h0010
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            int_hit_i,
  input  logic            lnk_hit_i,
  input  logic [ID_W-1:0] lnk_id_i,
  input  logic            clr_i,
  output logic [ID_W-1:0] id_o,
  output logic            flag_o
);
  logic [ID_W-1:0] id_q, id_d;
  logic            flag_q, flag_d;
  logic            cap;

  assign cap = !flag_q && (int_hit_i || lnk_hit_i);

  always_comb begin
    id_d   = id_q;
    flag_d = flag_q;
    if (cap) begin
      id_d   = lnk_hit_i ? lnk_id_i : LOCAL_ID;  // link message wins a tie
      flag_d = 1'b1;
    end else if (en_i && clr_i) begin
      flag_d = 1'b0;
    end
  end

  // only power-on reset clears sticky state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      id_q   <= id_d;
      flag_q <= flag_d;
    end
  end

  assign id_o   = id_q;
  assign flag_o = flag_q;

  p_hold_when_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |=> $stable(id_q));

  p_link_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && lnk_hit_i) |=> (id_q == $past(lnk_id_i)));

  p_local_id_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && int_hit_i && !lnk_hit_i) |=> (id_q == LOCAL_ID));

  p_cap_sets_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && (int_hit_i || lnk_hit_i)) |=> flag_q);

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && en_i && clr_i) |=> (!flag_q && $stable(id_q)));

  p_sys_rst_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(id_q) && $stable(flag_q)));
endmodule

// File: rtl/err_src_id_cap.sv
module err_src_id_cap
  import esid_pkg::*;
#(
  parameter int              ID_W     = 16,
  parameter logic [ID_W-1:0] LOCAL_ID = 16'h0010,
  localparam int             REG_W    = NUM_CLS * ID_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sys_rst_ni,
  input  logic             int_vld_i,
  input  logic [1:0]       int_cls_i,
  input  logic             lnk_vld_i,
  input  logic [1:0]       lnk_cls_i,
  input  logic [ID_W-1:0]  lnk_rid_i,
  input  logic             clr_ce_i,
  input  logic             clr_ue_i,
  output logic [REG_W-1:0] src_id_o,
  output logic             ce_first_o,
  output logic             ue_first_o
);
  logic                       en;
  logic     [NUM_SRC-1:0]     src_vld;
  err_cls_e [NUM_SRC-1:0]     src_cls;
  cls_hit_t [NUM_SRC-1:0]     src_hit;
  logic     [NUM_CLS-1:0]     int_hit, lnk_hit, clr, flag;
  logic     [NUM_CLS-1:0][ID_W-1:0] fld_id;

  assign en = sys_rst_ni;

  assign src_vld[SRC_INT] = int_vld_i;
  assign src_vld[SRC_LNK] = lnk_vld_i;
  assign src_cls[SRC_INT] = err_cls_e'(int_cls_i);
  assign src_cls[SRC_LNK] = err_cls_e'(lnk_cls_i);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    esid_classify u_cls (
      .vld_i (src_vld[s]),
      .cls_i (src_cls[s]),
      .en_i  (en),
      .hit_o (src_hit[s])
    );
  end

  assign int_hit = {src_hit[SRC_INT].unc, src_hit[SRC_INT].cor};
  assign lnk_hit = {src_hit[SRC_LNK].unc, src_hit[SRC_LNK].cor};
  assign clr     = {clr_ue_i, clr_ce_i};

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_fld
    esid_field #(.ID_W(ID_W), .LOCAL_ID(LOCAL_ID)) u_fld (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en),
      .int_hit_i (int_hit[c]),
      .lnk_hit_i (lnk_hit[c]),
      .lnk_id_i  (lnk_rid_i),
      .clr_i     (clr[c]),
      .id_o      (fld_id[c]),
      .flag_o    (flag[c])
    );
  end

  assign src_id_o   = fld_id;  // upper = uncorrectable, lower = correctable
  assign ce_first_o = flag[0];
  assign ue_first_o = flag[1];

  p_rsv_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_first_o && !ue_first_o && !(int_vld_i && int_cls_i != 2'b11)
     && !(lnk_vld_i && lnk_cls_i != 2'b11)) |=> ($stable(src_id_o)));

  p_both_classes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_ni && !ce_first_o && !ue_first_o && lnk_vld_i && lnk_cls_i == 2'b00
     && int_vld_i && int_cls_i[0] != int_cls_i[1])
    |=> (ce_first_o && ue_first_o));
endmodule

// File: tb/sim_err_src_id_cap.sv
module sim_err_src_id_cap;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0, sys_rst_ni = 1'b1;
  logic        int_vld = 1'b0, lnk_vld = 1'b0, clr_ce = 1'b0, clr_ue = 1'b0;
  logic [1:0]  int_cls = 2'b00, lnk_cls = 2'b00;
  logic [15:0] lnk_rid = '0;
  logic [31:0] src_id;
  logic        ce_first, ue_first;
  int checks = 0, failures = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  err_src_id_cap u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sys_rst_ni(sys_rst_ni),
    .int_vld_i(int_vld), .int_cls_i(int_cls),
    .lnk_vld_i(lnk_vld), .lnk_cls_i(lnk_cls), .lnk_rid_i(lnk_rid),
    .clr_ce_i(clr_ce), .clr_ue_i(clr_ue),
    .src_id_o(src_id), .ce_first_o(ce_first), .ue_first_o(ue_first)
  );

  typedef struct packed {
    logic        iv;
    logic [1:0]  ic;
    logic        lv;
    logic [1:0]  lc;
    logic [15:0] lr;
    logic        cc;
    logic        cu;
    logic [31:0] es;
    logic        ec;
    logic        eu;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'b00, 1'b0, 2'b00, 16'h0000, 1'b0, 1'b0, 32'h0000_0010, 1'b1, 1'b0},
    '{1'b0, 2'b00, 1'b1, 2'b00, 16'h1234, 1'b0, 1'b0, 32'h0000_0010, 1'b1, 1'b0},
    '{1'b1, 2'b10, 1'b1, 2'b01, 16'hABCD, 1'b0, 1'b0, 32'hABCD_0010, 1'b1, 1'b1},
    '{1'b0, 2'b00, 1'b0, 2'b00, 16'h0000, 1'b1, 1'b0, 32'hABCD_0010, 1'b0, 1'b1},
    '{1'b0, 2'b00, 1'b1, 2'b01, 16'h5555, 1'b0, 1'b1, 32'hABCD_0010, 1'b0, 1'b0},
    '{1'b1, 2'b10, 1'b1, 2'b00, 16'h2222, 1'b0, 1'b0, 32'h0010_2222, 1'b1, 1'b1},
    '{1'b0, 2'b00, 1'b0, 2'b00, 16'h0000, 1'b1, 1'b1, 32'h0010_2222, 1'b0, 1'b0},
    '{1'b1, 2'b11, 1'b1, 2'b11, 16'hFFFF, 1'b0, 1'b0, 32'h0010_2222, 1'b0, 1'b0},
    '{1'b0, 2'b00, 1'b1, 2'b01, 16'h0101, 1'b0, 1'b0, 32'h0101_2222, 1'b0, 1'b1},
    '{1'b0, 2'b00, 1'b1, 2'b00, 16'h0202, 1'b0, 1'b0, 32'h0101_0202, 1'b1, 1'b1}
  };

  function automatic string vec_req(int i);
    case (i)
      0: return "R5 R6";
      1: return "R3";
      2: return "R4 R2";
      3: return "R7";
      4: return "R7 clear-vs-error";
      5: return "R8 R4 R5";
      6: return "R7 both";
      7: return "R2 reserved";
      8: return "R2 nonfatal";
      default: return "R1 layout";
    endcase
  endfunction

  task automatic chk(string req, logic [33:0] act, logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    int_vld = 1'b0; lnk_vld = 1'b0; clr_ce = 1'b0; clr_ue = 1'b0;
    int_cls = 2'b00; lnk_cls = 2'b00; lnk_rid = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R1 reset", {src_id, ce_first, ue_first}, 34'h0);
    @(negedge clk) rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      int_vld = VEC[i].iv; int_cls = VEC[i].ic;
      lnk_vld = VEC[i].lv; lnk_cls = VEC[i].lc; lnk_rid = VEC[i].lr;
      clr_ce = VEC[i].cc; clr_ue = VEC[i].cu;
      @(posedge clk); #1;
      chk(vec_req(i), {src_id, ce_first, ue_first}, {VEC[i].es, VEC[i].ec, VEC[i].eu});
    end
    @(negedge clk) idle();

    // R9: system reset with live strobes and clears
    @(negedge clk);
    sys_rst_ni = 1'b0; clr_ce = 1'b1; clr_ue = 1'b1;
    repeat (2) @(posedge clk);
    #1 chk("R9 clear during sys reset", {src_id, ce_first, ue_first}, {32'h0101_0202, 2'b11});
    @(negedge clk);
    idle(); sys_rst_ni = 1'b0; lnk_vld = 1'b1; lnk_cls = 2'b00; lnk_rid = 16'h7777;
    @(posedge clk); #1;
    @(negedge clk);
    clr_ce = 1'b1; clr_ue = 1'b1; lnk_vld = 1'b0;
    @(posedge clk); #1;
    @(negedge clk) begin idle(); sys_rst_ni = 1'b1; end
    @(posedge clk); #1;
    chk("R9 after release", {src_id, ce_first, ue_first}, {32'h0101_0202, 2'b11});

    // R10: clear-then-capture timing, checked before and after the edge
    @(negedge clk) begin clr_ce = 1'b1; end
    @(posedge clk); #1;
    chk("R7 ce only", {src_id, ce_first, ue_first}, {32'h0101_0202, 2'b01});
    @(negedge clk) begin clr_ce = 1'b0; int_vld = 1'b1; int_cls = 2'b00; end
    #1 chk("R10 before edge", {src_id, ce_first, ue_first}, {32'h0101_0202, 2'b01});
    @(posedge clk); #1;
    chk("R10 after edge", {src_id, ce_first, ue_first}, {32'h0101_0010, 2'b11});
    @(negedge clk) idle();

    // R1: only power-on reset zeroes
    @(negedge clk) rst_ni = 1'b0;
    #1 chk("R1 power-on reset", {src_id, ce_first, ue_first}, 34'h0);
    @(negedge clk) rst_ni = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule